// File: doc/BRIEF.md
# Bit-Slice Secondary Configuration Address Generator

This block is support logic that lives inside a device which has already finished loading its own image. It walks a shared byte-wide parallel memory on behalf of up to eight secondary devices. Each bit of the memory word is wired on the board to the serial data input of one secondary. The block produces a 20-bit memory address, and that address begins at a programmable offset placed past the primary device's own image region. The address advances by one for each rising edge of the configuration clock, which is fed back into the block from the clock output pin.

After reset the block drives one low-high-low start pulse onto the shared reset line of the secondaries and keeps the memory selected while it counts. When the shared done line of the secondaries rises, the block locks. It freezes the counter, releases the address bus to high impedance through an enable output, deselects the memory and parks the start line high so that no stray reconfiguration can begin. The block takes its own done signal only from the secondaries' shared line. An active-low error input restarts the sequence from the offset, but only while the block has not yet locked.

Top module: `cfg_slice_addr_gen`

## Requirements
- R1: While reset is asserted, `start_o` is 0, `mem_cs_n` is 0, `addr_oe` is 1 and `addr_o` equals the OFFSET parameter.
- R2: After reset is released, `start_o` stays 0 for one cycle, is 1 for exactly PULSE_LEN cycles, and then returns to 0.
- R3: Once the start pulse has ended, `addr_o` increases by one for each rising edge of `cfg_clk_fb`, counting modulo 2^20. Each edge is seen through a two-flop synchronizer, and the new address appears on the third clock edge after the input rises.
- R4: Holding `cfg_clk_fb` high with no new rising edge leaves `addr_o` unchanged.
- R5: When `done_in` has been high for two synchronizer stages, the block locks on the next edge, which is the third clock edge after the rise. In lock, `addr_oe` goes to 0, meaning the address bus is at high impedance, and `addr_o` stays frozen.
- R6: In lock, `mem_cs_n` is 1 and `start_o` is 1. Lock holds until reset, even if `done_in` falls again.
- R7: A low `err_n` while the block is not locked reloads `addr_o` to OFFSET and issues a new start pulse of PULSE_LEN cycles.
- R8: In lock, a low `err_n` has no effect on any output.
- R9: If the synchronized done and a low `err_n` arrive in the same cycle, the block locks and does not reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_fb | input | 1 | Configuration clock fed back from the clock output pin |
| done_in | input | 1 | Shared done line of the secondaries (asynchronous) |
| err_n | input | 1 | Active-low error, restarts configuration before lock |
| addr_o | output | 20 | Memory address |
| addr_oe | output | 1 | Address bus drive enable (0 = high impedance) |
| mem_cs_n | output | 1 | Active-low memory chip select |
| start_o | output | 1 | Start pulse to the secondaries' reset inputs |

## Verification
The reference model is driven with several kinds of stimulus. Clean feedback-clock edges check the per-edge stepping and the wrap from 0xFFFFF to 0. A feedback clock held high shows that the block responds to edges and not to levels. An error pulse in the middle of counting shows that the block reloads and pulses again. A done rise that coincides with an error tells the lock priority apart from the restart. Error pulses and a falling done after lock show that the lock is sticky and cannot be disturbed.

// File: rtl/slice_cfg_pkg.sv
package slice_cfg_pkg;
  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,
    ST_PULSE = 2'd1,
    ST_RUN   = 2'd2,
    ST_LOCK  = 2'd3
  } seq_state_e;

  // address step, kept apart so the arithmetic is stated once
  function automatic logic [19:0] bump_addr(input logic [19:0] a);
    return a + 20'd1;
  endfunction
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/slice_seq.sv
module slice_seq
  import slice_cfg_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_s,
  input  logic       err_n,
  output seq_state_e state_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  seq_state_e      st_q, st_d;
  logic [CW-1:0]   cnt_q;
  logic            pulse_last;

  assign pulse_last = (cnt_q == CW'(PULSE_LEN - 1));

  always_comb begin
    st_d = st_q;
    if (done_s)                st_d = ST_LOCK;
    else if (st_q == ST_LOCK)  st_d = ST_LOCK;
    else if (!err_n)           st_d = ST_ARM;
    else begin
      case (st_q)
        ST_ARM:   st_d = ST_PULSE;
        ST_PULSE: st_d = pulse_last ? ST_RUN : ST_PULSE;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ARM;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_ARM)        cnt_q <= '0;
      else if (st_q == ST_PULSE) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/slice_addr_ctr.sv
module slice_addr_ctr
  import slice_cfg_pkg::*;
#(
  parameter int          ADDR_W = 20,
  parameter logic [19:0] OFFSET = 20'h08000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= OFFSET;
    else if (load)  addr <= OFFSET;
    else if (step)  addr <= bump_addr(addr);
  end
endmodule

// File: rtl/cfg_slice_addr_gen.sv
module cfg_slice_addr_gen
  import slice_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter logic [19:0] OFFSET    = 20'h08000,
  parameter int          PULSE_LEN = 4,
  parameter int          SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clk_fb,
  input  logic              done_in,
  input  logic              err_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe,
  output logic              mem_cs_n,
  output logic              start_o
);
  logic [1:0] raw_in, sync_out;
  logic       done_s, cfg_s, cfg_prev;
  logic       cfg_rise, step_ev, load_ev;
  seq_state_e st;

  assign raw_in = {done_in, cfg_clk_fb};

  sync_bits #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );
  assign cfg_s  = sync_out[0];
  assign done_s = sync_out[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_prev <= 1'b0;
    else        cfg_prev <= cfg_s;
  end
  assign cfg_rise = cfg_s & ~cfg_prev;

  slice_seq #(.PULSE_LEN(PULSE_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .done_s(done_s), .err_n(err_n), .state_o(st)
  );

  // named events for the checker
  assign load_ev = (st == ST_ARM);
  assign step_ev = (st == ST_RUN) & cfg_rise & ~done_s & err_n;

  slice_addr_ctr #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .step(step_ev), .addr(addr_o)
  );

  assign start_o  = (st == ST_PULSE) | (st == ST_LOCK);
  assign mem_cs_n = (st == ST_LOCK);
  assign addr_oe  = (st != ST_LOCK);
endmodule

// File: rtl/cfg_slice_chk.sv
module cfg_slice_chk #(
  parameter int          ADDR_W = 20,
  parameter logic [19:0] OFFSET = 20'h08000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_o,
  input logic              addr_oe,
  input logic              mem_cs_n,
  input logic              start_o,
  input logic              step_ev,
  input logic              load_ev
);
  // R3
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> addr_o == $past(addr_o) + ADDR_W'(1));
  // R4
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_ev && !load_ev) |=> $stable(addr_o));
  // R5
  frozen_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_oe |=> ($stable(addr_o) && !addr_oe));
  // R6
  lock_outs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (start_o && !addr_oe));
  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |=> mem_cs_n);
  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (addr_o == OFFSET));
endmodule

bind cfg_slice_addr_gen cfg_slice_chk #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_o(addr_o), .addr_oe(addr_oe),
  .mem_cs_n(mem_cs_n), .start_o(start_o), .step_ev(step_ev), .load_ev(load_ev)
);

// File: tb/cfg_slice_addr_gen_bench.sv
module cfg_slice_addr_gen_bench;
  localparam logic [19:0] TB_OFF = 20'hFFFFC;
  localparam int          PL     = 4;
  localparam int          MASK   = 20'hFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_clk_fb = 1'b0, done_in = 1'b0, err_n = 1'b1;
  logic [19:0] addr_o;
  logic        addr_oe, mem_cs_n, start_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_slice_addr_gen #(.OFFSET(TB_OFF), .PULSE_LEN(PL)) u_cfg_slice_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_clk_fb(cfg_clk_fb), .done_in(done_in),
    .err_n(err_n), .addr_o(addr_o), .addr_oe(addr_oe), .mem_cs_n(mem_cs_n),
    .start_o(start_o)
  );

  // behavioural reference: 0 arm, 1 pulse, 2 run, 3 lock
  int m_st = 0, m_cnt = 0, m_addr = int'(TB_OFF);
  int q_cfg[$] = '{0, 0, 0};
  int q_done[$] = '{0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_addr = int'(TB_OFF);
      q_cfg = '{0, 0, 0}; q_done = '{0, 0};
    end else begin
      int ns, nc, na;
      bit edge_seen, dn;
      edge_seen = (q_cfg[1] == 1) && (q_cfg[2] == 0);
      dn = (q_done[1] == 1);
      na = m_addr; nc = m_cnt; ns = m_st;
      if (m_st == 0) na = int'(TB_OFF);
      else if (m_st == 2 && edge_seen && !dn && err_n) na = (m_addr + 1) & MASK;
      if (m_st == 0) nc = 0; else if (m_st == 1) nc = m_cnt + 1;
      if (dn) ns = 3;
      else if (m_st == 3) ns = 3;
      else if (!err_n) ns = 0;
      else if (m_st == 0) ns = 1;
      else if (m_st == 1) ns = (m_cnt == PL - 1) ? 2 : 1;
      m_st = ns; m_cnt = nc; m_addr = na;
      q_cfg.push_front(int'(cfg_clk_fb)); void'(q_cfg.pop_back());
      q_done.push_front(int'(done_in));   void'(q_done.pop_back());
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      check("R3 addr_o model", int'(addr_o), m_addr);
      check("R2 start_o model", int'(start_o), int'(m_st == 1 || m_st == 3));
      check("R6 mem_cs_n model", int'(mem_cs_n), int'(m_st == 3));
      check("R5 addr_oe model", int'(addr_oe), int'(m_st != 3));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fb_edge();
    cfg_clk_fb = 1'b1; cyc(3);
    cfg_clk_fb = 1'b0; cyc(3);
  endtask

  initial begin
    int width;
    cyc(3);
    // R1 reset state
    check("R1 start", int'(start_o), 0);
    check("R1 cs_n", int'(mem_cs_n), 0);
    check("R1 oe", int'(addr_oe), 1);
    check("R1 addr", int'(addr_o), int'(TB_OFF));
    rst_n = 1'b1;
    // R2 width of start pulse
    width = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      if (start_o) width++;
    end
    check("R2 pulse width", width, PL);
    check("R2 start low after pulse", int'(start_o), 0);
    // R3 stepping and wrap
    for (int i = 0; i < 6; i++) fb_edge();
    check("R3 addr after 6 edges with wrap", int'(addr_o), 20'h00002);
    // R4 held level
    cfg_clk_fb = 1'b1; cyc(10);
    check("R4 addr with level held", int'(addr_o), 20'h00003);
    cfg_clk_fb = 1'b0; cyc(10);
    check("R4 addr after release", int'(addr_o), 20'h00003);
    // R7 error restart
    err_n = 1'b0; cyc(1); err_n = 1'b1;
    width = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      if (start_o) width++;
    end
    check("R7 new pulse width", width, PL);
    check("R7 reload addr", int'(addr_o), int'(TB_OFF));
    fb_edge(); fb_edge();
    check("R3 addr after 2 edges", int'(addr_o), 20'hFFFFE);
    // R9 done and error together at the synchronized edge
    done_in = 1'b1; cyc(2);
    err_n = 1'b0; cyc(1);
    err_n = 1'b1; cyc(2);
    check("R9 locked cs_n", int'(mem_cs_n), 1);
    check("R9 addr not reloaded", int'(addr_o), 20'hFFFFE);
    check("R5 oe off", int'(addr_oe), 0);
    check("R6 start parked", int'(start_o), 1);
    // R6 R8 sticky lock
    done_in = 1'b0;
    fb_edge(); fb_edge();
    err_n = 1'b0; cyc(3); err_n = 1'b1; cyc(5);
    check("R8 cs_n after err", int'(mem_cs_n), 1);
    check("R8 start after err", int'(start_o), 1);
    check("R5 addr frozen", int'(addr_o), 20'hFFFFE);
    check("R6 oe still off", int'(addr_oe), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule